// File: doc/BRIEF.md
# Programmable Sync Pulse Generator

This block produces and distributes the synchronization strobes used across a mixing and carrier-tracking datapath. A free-running 20-bit counter gives a periodic terminal-count strobe. Its period is a multiple of sixteen clocks, set by a 16-bit period word. Two active-low external sync pins are registered. Each pin also feeds its own programmable delay of up to 258 clocks. A software one-shot request adds a sixth strobe source.

Five internal consumers each pick one source through their own 3-bit select field: the period counter, symbol alignment, snapshot capture, the tracking loop and the oscillator. The sync output pin has its own select field from the same set. A consumer can also be left free-running. When the counter's own selection fires, the counter restarts. The low twelve counter bits are exported as a ramp for diagnostic data injection.

Top module: `sync_pulse_gen`

## Requirements
- R1: While `rst_n` is low, `ramp`, `dst_sync` and `sync_out` are all zero, and no delayed event is pending.
- R2: The counter starts at 0 after reset and advances by one each clock. It returns to 0 after 16*(P+1) clocks, where P is `period_cfg`. `ramp` carries its low 12 bits.
- R3: The terminal-count source is high for exactly one cycle, in the cycle where the counter holds 16*(P+1)-1.
- R4: `sync_a_n` and `sync_b_n` are active low. A pin sampled low at a clock edge makes source A (or B) high for the following cycle.
- R5: Take a registered event and a delay setting D. Delayed source A (or B) goes high exactly D cycles after the cycle in which source A (or B) was high. D=0 gives the same cycle. Any setting above 258 behaves as 258.
- R6: Each delay tracks one pending event. A new registered event that arrives while one is pending restarts the delay, and the earlier event produces no pulse.
- R7: `oneshot_req` high at a clock edge makes the one-shot source high for the following cycle.
- R8: Each 3-bit select code maps to a source: 0 none, 1 A, 2 B, 3 delayed A, 4 delayed B, 5 terminal count, 6 one-shot, 7 none. Consumer i uses `dst_sel[3i+2:3i]` and drives `dst_sync[i]`, where i=0 is the counter, 1 symbol align, 2 snapshot, 3 tracking loop and 4 oscillator. `out_sel` drives `sync_out` with the same codes.
- R9: When `dst_sync[0]` is high in a cycle, the counter holds 0 in the next cycle and counts on from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_a_n | input | 1 | External sync A, active low |
| sync_b_n | input | 1 | External sync B, active low |
| oneshot_req | input | 1 | Software one-shot request |
| period_cfg | input | 16 | Counter period word P, period 16*(P+1) |
| dly_a_cfg | input | 9 | Delay for sync A in clocks |
| dly_b_cfg | input | 9 | Delay for sync B in clocks |
| dst_sel | input | 15 | Five 3-bit consumer select fields |
| out_sel | input | 3 | Sync output select code |
| dst_sync | output | 5 | Per-consumer sync strobes |
| sync_out | output | 1 | Selected sync for the output pin |
| ramp | output | 12 | Low 12 counter bits |

## Verification
On every cycle the assertions check the local counter and register rules. The ramp steps by one unless a wrap or restart comes first. The terminal count is followed by a zero ramp and never lasts two cycles. A restart clears the counter. The external pins and the one-shot request show up one cycle later, and the two never codes keep the output low. Other behaviours show only across many cycles, so only the bench scenarios can bring them out: the full period length for several period words, the exact arrival cycle of delayed pulses including the clamp at 258, the drop of a superseded pending event, and the per-consumer routing.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;
    localparam int SEL_W   = 3;
    localparam int NUM_SRC = 1 << SEL_W;

    typedef enum logic [SEL_W-1:0] {
        SRC_NONE = 3'd0,
        SRC_A    = 3'd1,
        SRC_B    = 3'd2,
        SRC_DA   = 3'd3,
        SRC_DB   = 3'd4,
        SRC_TC   = 3'd5,
        SRC_OS   = 3'd6,
        SRC_OFF  = 3'd7
    } sync_src_e;
endpackage

// File: rtl/sync_period_counter.sv
module sync_period_counter #(
    parameter int PER_W   = 16,
    parameter int PRESC_W = 4,
    parameter int RAMP_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  period_i,
    input  logic              resync_i,
    output logic              tc_o,
    output logic [RAMP_W-1:0] ramp_o
);
    localparam int CNT_W = PER_W + PRESC_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] last_val;

    always_comb begin
        // 16*(P+1)-1 is P with four ones appended: no adder needed
        last_val = {period_i, {PRESC_W{1'b1}}};
        tc_o     = (st_q.cnt >= last_val);
        st_d     = st_q;
        if (resync_i || tc_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ramp_o = st_q.cnt[RAMP_W-1:0];
endmodule

// File: rtl/sync_delay_line.sv
module sync_delay_line #(
    parameter int DLY_W   = 9,
    parameter int DLY_MAX = 258
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_i,
    input  logic [DLY_W-1:0] dly_cfg_i,
    output logic             dly_o
);
    localparam logic [DLY_W-1:0] DLY_LIM = DLY_W'(DLY_MAX);

    typedef struct packed {
        logic             pend;
        logic [DLY_W-1:0] cnt;
    } dly_state_t;

    dly_state_t       st_d, st_q;
    logic [DLY_W-1:0] eff_dly;
    logic             fire;

    always_comb begin
        eff_dly = (dly_cfg_i > DLY_LIM) ? DLY_LIM : dly_cfg_i;
        fire    = st_q.pend && (st_q.cnt == '0);
        dly_o   = (eff_dly == '0) ? ev_i : fire;
        st_d    = st_q;
        if (ev_i && (eff_dly != '0)) begin
            // newest event replaces whatever is pending
            st_d.pend = 1'b1;
            st_d.cnt  = eff_dly - DLY_W'(1);
        end else if (fire) begin
            st_d.pend = 1'b0;
        end else if (st_q.pend) begin
            st_d.cnt = st_q.cnt - DLY_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sync_source_mux.sv
module sync_source_mux
    import sync_gen_pkg::*;
(
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               sync_o
);
    always_comb begin
        sync_o = src_i[sel_i];
    end
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
    import sync_gen_pkg::*;
#(
    parameter int PER_W   = 16,
    parameter int PRESC_W = 4,
    parameter int RAMP_W  = 12,
    parameter int DLY_W   = 9,
    parameter int DLY_MAX = 258,
    parameter int NUM_DST = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sync_a_n,
    input  logic                     sync_b_n,
    input  logic                     oneshot_req,
    input  logic [PER_W-1:0]         period_cfg,
    input  logic [DLY_W-1:0]         dly_a_cfg,
    input  logic [DLY_W-1:0]         dly_b_cfg,
    input  logic [NUM_DST*SEL_W-1:0] dst_sel,
    input  logic [SEL_W-1:0]         out_sel,
    output logic [NUM_DST-1:0]       dst_sync,
    output logic                     sync_out,
    output logic [RAMP_W-1:0]        ramp
);
    localparam int NUM_ROUTE = NUM_DST + 1;

    typedef struct packed {
        logic a;
        logic b;
        logic os;
    } in_state_t;

    in_state_t            in_d, in_q;
    logic [NUM_SRC-1:0]   src_vec;
    logic                 dly_a, dly_b, tc;
    logic [NUM_ROUTE-1:0] route;

    always_comb begin
        in_d.a  = ~sync_a_n;
        in_d.b  = ~sync_b_n;
        in_d.os = oneshot_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q <= '0;
        end else begin
            in_q <= in_d;
        end
    end

    sync_delay_line #(.DLY_W(DLY_W), .DLY_MAX(DLY_MAX)) dly_a_i (
        .clk(clk), .rst_n(rst_n), .ev_i(in_q.a), .dly_cfg_i(dly_a_cfg), .dly_o(dly_a)
    );

    sync_delay_line #(.DLY_W(DLY_W), .DLY_MAX(DLY_MAX)) dly_b_i (
        .clk(clk), .rst_n(rst_n), .ev_i(in_q.b), .dly_cfg_i(dly_b_cfg), .dly_o(dly_b)
    );

    sync_period_counter #(.PER_W(PER_W), .PRESC_W(PRESC_W), .RAMP_W(RAMP_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .period_i(period_cfg), .resync_i(route[0]),
        .tc_o(tc), .ramp_o(ramp)
    );

    always_comb begin
        src_vec         = '0;
        src_vec[SRC_A]  = in_q.a;
        src_vec[SRC_B]  = in_q.b;
        src_vec[SRC_DA] = dly_a;
        src_vec[SRC_DB] = dly_b;
        src_vec[SRC_TC] = tc;
        src_vec[SRC_OS] = in_q.os;
    end

    for (genvar gi = 0; gi < NUM_ROUTE; gi++) begin : g_route
        logic [SEL_W-1:0] sel;
        if (gi < NUM_DST) begin : g_dst
            assign sel = dst_sel[gi*SEL_W +: SEL_W];
        end else begin : g_pin
            assign sel = out_sel;
        end
        sync_source_mux mux_i (.src_i(src_vec), .sel_i(sel), .sync_o(route[gi]));
    end

    assign dst_sync = route[NUM_DST-1:0];
    assign sync_out = route[NUM_DST];
endmodule

// File: rtl/sync_pulse_gen_chk.sv
module sync_pulse_gen_chk #(
    parameter int RAMP_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_a_n,
    input logic              oneshot_req,
    input logic [2:0]        out_sel,
    input logic              sync_out,
    input logic [RAMP_W-1:0] ramp,
    input logic              tc,
    input logic              resync,
    input logic              src_a,
    input logic              src_os
);
    // R2
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tc && !resync) |=> (ramp == RAMP_W'($past(ramp) + 1'b1)));

    // R3
    tc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> (ramp == '0));

    // R3
    tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);

    // R9
    resync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> (ramp == '0));

    // R4
    pin_a_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (src_a == !$past(sync_a_n)));

    // R7
    oneshot_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (src_os == $past(oneshot_req)));

    // R8
    out_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_sel == 3'd0) || (out_sel == 3'd7)) |-> !sync_out);
endmodule

bind sync_pulse_gen sync_pulse_gen_chk #(.RAMP_W(RAMP_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .sync_a_n(sync_a_n), .oneshot_req(oneshot_req),
    .out_sel(out_sel), .sync_out(sync_out), .ramp(ramp), .tc(tc),
    .resync(dst_sync[0]), .src_a(in_q.a), .src_os(in_q.os)
);

// File: tb/sync_pulse_gen_tb_top.sv
module sync_pulse_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    cyc;
        int    kind;   // 0 dst_sync, 1 sync_out, 2 ramp
        int    val;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_a_n = 1'b1, sync_b_n = 1'b1, oneshot_req = 1'b0;
    logic [15:0] period_cfg = 16'd2;
    logic [8:0]  dly_a_cfg = '0, dly_b_cfg = '0;
    logic [14:0] dst_sel = '0;
    logic [2:0]  out_sel = '0;
    logic [4:0]  dst_sync;
    logic        sync_out;
    logic [11:0] ramp;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   c0 = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];
    int   win_dst[int];
    int   win_out[int];

    sync_pulse_gen dut_i (
        .clk(clk), .rst_n(rst_n), .sync_a_n(sync_a_n), .sync_b_n(sync_b_n),
        .oneshot_req(oneshot_req), .period_cfg(period_cfg), .dly_a_cfg(dly_a_cfg),
        .dly_b_cfg(dly_b_cfg), .dst_sel(dst_sel), .out_sel(out_sel),
        .dst_sync(dst_sync), .sync_out(sync_out), .ramp(ramp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // monitor: pops due scoreboard items a quarter period after each edge
    always @(posedge clk) begin
        cyc++;
        #(CLK_PERIOD/4);
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].cyc <= cyc) begin
                if (sb_q[i].cyc < cyc) begin
                    check({sb_q[i].tag, " missed"}, 0, 1);
                end else if (sb_q[i].kind == 0) begin
                    check({sb_q[i].tag, " dst_sync"}, int'(dst_sync), sb_q[i].val);
                end else if (sb_q[i].kind == 1) begin
                    check({sb_q[i].tag, " sync_out"}, int'(sync_out), sb_q[i].val);
                end else begin
                    check({sb_q[i].tag, " ramp"}, int'(ramp), sb_q[i].val);
                end
                sb_q.delete(i);
            end
        end
    end

    task automatic push(int c, int kind, int val, string tag);
        exp_t it;
        it.cyc = c; it.kind = kind; it.val = val; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic push_window(int from, int to, string tag);
        for (int c = from; c <= to; c++) begin
            push(c, 0, win_dst.exists(c) ? win_dst[c] : 0, tag);
            push(c, 1, win_out.exists(c) ? win_out[c] : 0, tag);
        end
        win_dst.delete();
        win_out.delete();
    endtask

    task automatic wait_to(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset ramp", int'(ramp), 0);
        check("R1 reset dst_sync", int'(dst_sync), 0);
        check("R1 reset sync_out", int'(sync_out), 0);
        rst_n = 1'b1;
        c0 = cyc;
    endtask

    task automatic pulse_a(int at);
        wait_to(at); sync_a_n = 1'b0; @(negedge clk); sync_a_n = 1'b1;
    endtask

    task automatic pulse_b(int at);
        wait_to(at); sync_b_n = 1'b0; @(negedge clk); sync_b_n = 1'b1;
    endtask

    task automatic pulse_os(int at);
        wait_to(at); oneshot_req = 1'b1; @(negedge clk); oneshot_req = 1'b0;
    endtask

    initial begin
        int x, y, z, p;
        // R2 R3 R8: period 48, every consumer and the pin follow terminal count
        period_cfg = 16'd2; dst_sel = {5{3'd5}}; out_sel = 3'd5;
        apply_reset();
        for (int j = 1; j <= 110; j++) begin
            push(c0 + j, 2, j % 48, "R2 period48");
            push(c0 + j, 1, (j % 48 == 47) ? 1 : 0, "R3 tc48");
            push(c0 + j, 0, (j % 48 == 47) ? 31 : 0, "R8 tc route");
        end
        wait_to(c0 + 112);

        // R2 R3: shortest period of 16
        period_cfg = 16'd0; dst_sel = '0; out_sel = 3'd5;
        apply_reset();
        for (int j = 1; j <= 40; j++) begin
            push(c0 + j, 2, j % 16, "R2 period16");
            push(c0 + j, 1, (j % 16 == 15) ? 1 : 0, "R3 tc16");
        end
        wait_to(c0 + 42);

        // R2 R3: period 4816, counter passes beyond 12 ramp bits
        period_cfg = 16'd300;
        apply_reset();
        push(c0 + 4100, 2, 4, "R2 ramp wrap12");
        push(c0 + 4814, 1, 0, "R3 before tc");
        push(c0 + 4815, 1, 1, "R3 tc4816");
        push(c0 + 4816, 2, 0, "R2 period4816");
        push(c0 + 4816, 1, 0, "R3 tc one cycle");
        wait_to(c0 + 4818);

        // R4 R5 R7 R8: routing, delays 5 and 258, one-shot to the pin
        period_cfg = 16'hFFFF; dly_a_cfg = 9'd5; dly_b_cfg = 9'd258;
        dst_sel = {3'd4, 3'd3, 3'd2, 3'd1, 3'd0}; out_sel = 3'd6;
        apply_reset();
        x = c0 + 5; y = c0 + 8; z = c0 + 12;
        win_dst[x + 1] = 5'b00010;
        win_dst[x + 6] = 5'b01000;
        win_dst[y + 1] = 5'b00100;
        win_dst[y + 259] = 5'b10000;
        win_out[z + 1] = 1;
        push_window(c0 + 1, c0 + 300, "R4 R5 R7 R8 route");
        pulse_a(x); pulse_b(y); pulse_os(z);
        wait_to(c0 + 302);

        // R5 R8: zero delay, clamp of 300 to 258, never code 7 on the pin
        dly_a_cfg = 9'd0; dly_b_cfg = 9'd300; out_sel = 3'd7;
        apply_reset();
        x = c0 + 4; y = c0 + 6; z = c0 + 9;
        win_dst[x + 1] = 5'b01010;
        win_dst[y + 1] = 5'b00100;
        win_dst[y + 259] = 5'b10000;
        push_window(c0 + 1, c0 + 280, "R5 R8 clamp");
        pulse_a(x); pulse_b(y); pulse_os(z);
        wait_to(c0 + 282);

        // R6: second event while pending restarts the delay
        dly_a_cfg = 9'd10; out_sel = 3'd3;
        apply_reset();
        x = c0 + 4;
        win_dst[x + 1] = 5'b00010;
        win_dst[x + 5] = 5'b00010;
        win_dst[x + 15] = 5'b01000;
        win_out[x + 15] = 1;
        push_window(c0 + 1, c0 + 40, "R6 retrigger");
        pulse_a(x); pulse_a(x + 4);
        wait_to(c0 + 42);

        // R9: counter restarts on its own selected sync (A)
        period_cfg = 16'd0; dly_a_cfg = 9'd0; dst_sel = {12'd0, 3'd1}; out_sel = 3'd5;
        apply_reset();
        x = c0 + 20;
        for (int j = 1; j <= 21; j++) push(c0 + j, 2, j % 16, "R9 before resync");
        push(x + 1, 0, 1, "R9 resync strobe");
        for (int k = 0; k <= 40; k++) begin
            p = k % 16;
            push(x + 2 + k, 2, p, "R9 after resync");
            push(x + 2 + k, 1, (p == 15) ? 1 : 0, "R9 tc after resync");
        end
        pulse_a(x);
        wait_to(x + 45);

        while (sb_q.size() != 0) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule